// File: doc/BRIEF.md
# Configuration Watchdog Timer with Factory Fallback

This block guards a device that holds two configuration images: a trusted factory image and a field-updatable application image. Once the application image has finished configuring and entered user mode, a down-counter starts from a programmed timeout. The running application has to strobe an active-low kick input now and then, and each kick puts the counter back to its programmed value. If the counter runs out without a kick, the block latches a sticky watchdog status flag and pulses a request to fall back to the factory image.

The timeout is programmed only in coarse steps. A narrow setting is placed above a run of all-ones low bits in a wide counter, so each unit of the setting adds 2^SHIFT oscillator cycles. Real timeout lengths therefore follow the actual rate of the free-running oscillator, which may lie anywhere from about 5 to 10 MHz. The timer is held off while configuration is in progress and whenever the factory image is running. Only the factory image can clear the status flag.

The block has no data stream, so every pin is a plain level or pulse with no valid/ready handshake. No back-pressure applies: the reconfiguration request is a single-cycle pulse that the loader must take when it appears.

Top module: `cfg_wdog`

## Requirements
- R1: While rst_n is low, wd_status and reconfig_req are 0 and count reads all ones.
- R2: The reload value has timeout_sel in bits [SHIFT+SET_W-1:SHIFT], all ones in bits [SHIFT-1:0] and zeros above. A timeout_sel of 0 is loaded as if it were 1.
- R3: While user_mode is 0 (configuration in progress), count follows the reload value every cycle and reconfig_req stays 0.
- R4: While app_mode is 0 (factory image), count follows the reload value every cycle and reconfig_req stays 0, whatever user_mode is.
- R5: While app_mode and user_mode are both 1 and kick_n is 1, count falls by exactly one per clock while it is non-zero.
- R6: A clock edge with the timer active and kick_n at 0 loads count with the reload value.
- R7: An active clock edge with count at 0 and kick_n at 1 is an expiry. In the next cycle reconfig_req is 1 for exactly one cycle, wd_status is 1, and count holds the reload value again.
- R8: A kick at the same edge where count is 0 takes priority. count reloads and no expiry is raised.
- R9: wd_status stays set until rst_n or an edge with status_clr at 1 and app_mode at 0. status_clr has no effect while app_mode is 1.
- R10: After the timer becomes active with count at reload value L and no kick arrives, the first reconfig_req appears after exactly L+1 active edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| timeout_sel | input | SET_W | Coarse timeout setting |
| app_mode | input | 1 | 1 = application image running, 0 = factory image |
| user_mode | input | 1 | 1 = configuration done, device in user mode |
| kick_n | input | 1 | Active-low watchdog reload |
| status_clr | input | 1 | Clears wd_status, honoured only while app_mode is 0 |
| wd_status | output | 1 | Sticky watchdog expiry flag |
| reconfig_req | output | 1 | One-cycle request to reload the factory image |
| count | output | CNT_W | Current counter value |

## Verification
The bench targets the cycle where count is zero. If the design expired one edge early or one edge late, the request would come at the wrong point, so R10 is measured exactly. The same zero-count edge is hit with a kick at the same time; a design that put expiry ahead of the kick would fire the request there. A zero setting is also applied, and a design that read zero as "disabled" or as a zero-length timeout would show the wrong count. The bench further tries to clear the status flag from the application image, tries to run the timer in the factory image and during configuration, and checks that the request drops after a single cycle rather than staying high.

// File: rtl/cfg_wdog_pkg.sv
package cfg_wdog_pkg;
  typedef enum logic [1:0] {
    WD_ACT_LOAD   = 2'd0,
    WD_ACT_DEC    = 2'd1,
    WD_ACT_EXPIRE = 2'd2
  } wd_act_e;
endpackage

// File: rtl/cfg_wdog_load.sv
module cfg_wdog_load #(
  parameter int CNT_W = 29,
  parameter int SET_W = 12,
  parameter int SHIFT = CNT_W - SET_W
) (
  input  logic [SET_W-1:0] timeout_sel,
  output logic [CNT_W-1:0] load_val
);
  localparam int PAD_W = CNT_W - SET_W - SHIFT;

  logic [SET_W-1:0] eff_sel;

  always_comb begin
    eff_sel = timeout_sel;
    if (timeout_sel == '0) eff_sel = SET_W'(1);
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign load_val = {{PAD_W{1'b0}}, eff_sel, {SHIFT{1'b1}}};
    end else begin : g_nopad
      assign load_val = {eff_sel, {SHIFT{1'b1}}};
    end
  endgenerate
endmodule

// File: rtl/cfg_wdog_ctl.sv
module cfg_wdog_ctl
  import cfg_wdog_pkg::*;
(
  input  logic    app_mode,
  input  logic    user_mode,
  input  logic    kick_n,
  input  logic    cnt_zero,
  output wd_act_e act
);
  logic active;

  assign active = app_mode & user_mode;

  always_comb begin
    if (!active || !kick_n) act = WD_ACT_LOAD;
    else if (cnt_zero)      act = WD_ACT_EXPIRE;
    else                    act = WD_ACT_DEC;
  end
endmodule

// File: rtl/cfg_wdog_cnt.sv
module cfg_wdog_cnt
  import cfg_wdog_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wd_act_e          act,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
    end else begin
      case (act)
        WD_ACT_DEC: cnt_q <= cnt_q - CNT_W'(1);
        default:    cnt_q <= load_val;
      endcase
    end
  end

  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/cfg_wdog_stat.sv
module cfg_wdog_stat
  import cfg_wdog_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  wd_act_e act,
  input  logic    app_mode,
  input  logic    status_clr,
  output logic    wd_status,
  output logic    reconfig_req
);
  logic expire;

  assign expire = (act == WD_ACT_EXPIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_status    <= 1'b0;
      reconfig_req <= 1'b0;
    end else begin
      reconfig_req <= expire;
      if (expire)                       wd_status <= 1'b1;
      else if (status_clr && !app_mode) wd_status <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_wdog.sv
module cfg_wdog
  import cfg_wdog_pkg::*;
#(
  parameter int CNT_W = 29,
  parameter int SET_W = 12,
  parameter int SHIFT = CNT_W - SET_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] timeout_sel,
  input  logic             app_mode,
  input  logic             user_mode,
  input  logic             kick_n,
  input  logic             status_clr,
  output logic             wd_status,
  output logic             reconfig_req,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] load_val;
  logic             cnt_zero;
  wd_act_e          act;

  cfg_wdog_load #(.CNT_W(CNT_W), .SET_W(SET_W), .SHIFT(SHIFT)) load_i (
    .timeout_sel (timeout_sel),
    .load_val    (load_val)
  );

  cfg_wdog_ctl ctl_i (
    .app_mode  (app_mode),
    .user_mode (user_mode),
    .kick_n    (kick_n),
    .cnt_zero  (cnt_zero),
    .act       (act)
  );

  cfg_wdog_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .load_val (load_val),
    .cnt_q    (count),
    .cnt_zero (cnt_zero)
  );

  cfg_wdog_stat stat_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .act          (act),
    .app_mode     (app_mode),
    .status_clr   (status_clr),
    .wd_status    (wd_status),
    .reconfig_req (reconfig_req)
  );
endmodule

// File: rtl/cfg_wdog_chk.sv
module cfg_wdog_chk #(
  parameter int CNT_W = 29,
  parameter int SET_W = 12,
  parameter int SHIFT = CNT_W - SET_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SET_W-1:0] timeout_sel,
  input logic             app_mode,
  input logic             user_mode,
  input logic             kick_n,
  input logic             status_clr,
  input logic             wd_status,
  input logic             reconfig_req,
  input logic [CNT_W-1:0] count
);
  logic [SET_W-1:0] sel_eff;
  logic [CNT_W-1:0] exp_load;
  logic             run;

  assign sel_eff  = (timeout_sel == '0) ? SET_W'(1) : timeout_sel;
  assign exp_load = (CNT_W'(sel_eff) << SHIFT) | ~({CNT_W{1'b1}} << SHIFT);
  assign run      = app_mode && user_mode;

  always_comb begin
    if (!rst_n) begin
      AST_RESET_STATE: assert (!wd_status && !reconfig_req); // R1
    end
  end

  AST_IDLE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == $past(exp_load) && !reconfig_req)); // R3

  AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !kick_n) |=> (count == $past(exp_load) && !reconfig_req)); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && kick_n && count != '0) |=> (count == $past(count) - CNT_W'(1))); // R5

  AST_EXPIRE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (run && kick_n && count == '0) |=> (reconfig_req && wd_status)); // R7

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reconfig_req |=> !reconfig_req); // R7

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_status && !(status_clr && !app_mode)) |=> wd_status); // R9
endmodule

bind cfg_wdog cfg_wdog_chk #(.CNT_W(CNT_W), .SET_W(SET_W), .SHIFT(SHIFT)) chk_i (.*);

// File: tb/cfg_wdog_tb_top.sv
module cfg_wdog_tb_top;
  localparam int CNT_W = 10;
  localparam int SET_W = 4;
  localparam int SHIFT = CNT_W - SET_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [SET_W-1:0] timeout_sel;
  logic             app_mode, user_mode, kick_n, status_clr;
  logic             wd_status, reconfig_req;
  logic [CNT_W-1:0] count;

  int total = 0;
  int bad   = 0;
  int req_seen;

  always #2 clk = ~clk;

  cfg_wdog #(.CNT_W(CNT_W), .SET_W(SET_W), .SHIFT(SHIFT)) dut_i (.*);

  // {setting[4], active cycles[12], expected req[1], pad[5], expected count[10]}
  localparam logic [31:0] VEC [5] = '{
    {4'd1, 12'd10,  1'b0, 5'd0, 10'd117},
    {4'd2, 12'd100, 1'b0, 5'd0, 10'd91},
    {4'd0, 12'd127, 1'b0, 5'd0, 10'd0},
    {4'd3, 12'd50,  1'b0, 5'd0, 10'd205},
    {4'd1, 12'd128, 1'b1, 5'd0, 10'd127}
  };

  function automatic int lval(int s);
    int e = (s == 0) ? 1 : s;
    return (e << SHIFT) | ((1 << SHIFT) - 1);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (reconfig_req) req_seen++;
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; timeout_sel = 4'd1; app_mode = 1'b1; user_mode = 1'b0;
    kick_n = 1'b1; status_clr = 1'b0;
    #11;
    chk("R1 count", int'(count), 1023);
    chk("R1 status", int'(wd_status), 0);
    chk("R1 req", int'(reconfig_req), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R5 / R10
    for (int v = 0; v < 5; v++) begin
      user_mode = 1'b0;
      timeout_sel = VEC[v][31:28];
      step(1);
      user_mode = 1'b1;
      req_seen = 0;
      step(int'(VEC[v][27:16]));
      chk("R5/R10 vec count", int'(count), int'(VEC[v][9:0]));
      chk("R10 vec req", int'(reconfig_req), int'(VEC[v][15]));
      user_mode = 1'b0;
      step(1);
    end

    // R2 reload values
    timeout_sel = 4'd15; step(1);
    chk("R2 set15", int'(count), lval(15));
    timeout_sel = 4'd0; step(1);
    chk("R2 set0", int'(count), 127);

    // R9 clear from factory after table expiry
    app_mode = 1'b1; status_clr = 1'b1; step(1);
    chk("R9 clr ignored in app", int'(wd_status), 1);
    app_mode = 1'b0; step(1);
    chk("R9 clr in factory", int'(wd_status), 0);
    status_clr = 1'b0;

    // R4 factory image: timer disabled
    user_mode = 1'b1; req_seen = 0; step(300);
    chk("R4 count", int'(count), 127);
    chk("R4 no req", req_seen, 0);

    // R3 configuring: disabled, tracks setting
    app_mode = 1'b1; user_mode = 1'b0; timeout_sel = 4'd2; req_seen = 0;
    step(300);
    chk("R3 count", int'(count), 191);
    chk("R3 no req", req_seen, 0);

    // R6 kick reload
    timeout_sel = 4'd1; step(1);
    user_mode = 1'b1; step(20);
    chk("R5 count", int'(count), 107);
    kick_n = 1'b0; step(1); kick_n = 1'b1;
    chk("R6 reload", int'(count), 127);
    step(1);
    chk("R6 resume", int'(count), 126);

    // R8 kick at zero wins
    step(126);
    chk("R8 at zero", int'(count), 0);
    req_seen = 0;
    kick_n = 1'b0; step(1); kick_n = 1'b1;
    chk("R8 reloaded", int'(count), 127);
    chk("R8 no req", req_seen, 0);
    chk("R8 status", int'(wd_status), 0);

    // R7 expiry pulse
    step(127);
    chk("R7 pre", int'(reconfig_req), 0);
    step(1);
    chk("R7 req", int'(reconfig_req), 1);
    chk("R7 status", int'(wd_status), 1);
    chk("R7 count", int'(count), 127);
    step(1);
    chk("R7 pulse ends", int'(reconfig_req), 0);
    chk("R9 sticky", int'(wd_status), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule